// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block holds a small table of words and answers one question quickly: which entries agree with a search value on a chosen set of bit positions. The write port loads one entry at a time by address and sets or clears that entry's valid flag. A search presents an argument and a key. The key selects the bit positions that are compared. Every entry is compared in the same cycle, and the per-entry results are stored in a match register.

The match register drives a read-out stage. That stage picks the lowest-numbered entry whose match bit is set. It reports that entry's index and its stored word, and raises a flag whenever at least one bit in the match register is set. A search loads the match register on the clock edge where it is issued, and the results appear one clock later. The register keeps its value until the next search. A write issued in the same cycle as a search is not seen by that search. It is seen by the search that follows.

Top module: `mcam_top`

## Requirements
- R1: After reset, every entry is invalid and the match register is zero. A search with any argument and key then returns an all-zero match.
- R2: When `wr_en_i` is high, the entry at `wr_addr_i` takes `wr_data_i` and takes `wr_valid_i` as its valid flag. Writing `wr_valid_i`=0 removes the entry from all later searches.
- R3: Entry i matches when its stored word equals `arg_i` at every bit position where `key_i` is 1. Bit positions where `key_i` is 0 are ignored.
- R4: All entries are compared against the same argument in the same cycle. Bit i of `match_o` is the result for entry i. It is loaded on the edge where `srch_en_i` is high and is visible from the next cycle.
- R5: An invalid entry never sets its bit in `match_o`, even when its stored word would match.
- R6: When `hit_o` is 1, `hit_idx_o` is the lowest index whose `match_o` bit is set. `rd_data_o` is the word currently stored at that index.
- R7: `hit_o` is 1 exactly when at least one bit of `match_o` is set.
- R8: A write issued in the same cycle as a search does not affect that search's result. The write does affect the next search.
- R9: An all-zero key makes every valid entry match, whatever the argument is.
- R10: While `srch_en_i` is low, `match_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write one entry this cycle |
| wr_addr_i | input | $clog2(ENTRIES) | Index of the entry to write |
| wr_data_i | input | WIDTH | Word to store |
| wr_valid_i | input | 1 | Valid flag stored with the word |
| srch_en_i | input | 1 | Load the match register from this cycle's compare |
| arg_i | input | WIDTH | Search argument |
| key_i | input | WIDTH | Compare mask; 1 means the bit position is compared |
| match_o | output | ENTRIES | Match register, bit i for entry i |
| hit_o | output | 1 | At least one match bit is set |
| hit_idx_o | output | $clog2(ENTRIES) | Lowest matching index |
| rd_data_o | output | WIDTH | Stored word at `hit_idx_o` |

## Verification
A fault in a stored word or a valid flag shows up at `match_o` one cycle after the first search that touches that entry. It shows as a bit that is set or cleared against the model. With a key of zero, a stuck valid flag shows up whatever the data is. A fault in the match register or the priority stage changes `hit_idx_o` or `rd_data_o` in the same cycle as the bad match bit. The bench checks these outputs after every search. It also checks that the match register stays constant across idle cycles, so a register that reloads when it should not is caught on the first idle check.

// File: rtl/mcam_pkg.sv
package mcam_pkg;
  parameter int unsigned DEF_ENTRIES = 8;
  parameter int unsigned DEF_WIDTH   = 16;
endpackage

// File: rtl/mcam_store.sv
module mcam_store #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned WIDTH   = 16,
  localparam int unsigned AW     = $clog2(ENTRIES)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [AW-1:0]                  wr_addr_i,
  input  logic [WIDTH-1:0]               wr_data_i,
  input  logic                           wr_valid_i,
  output logic [ENTRIES-1:0][WIDTH-1:0]  words_o,
  output logic [ENTRIES-1:0]             valid_o
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    logic sel;
    assign sel = wr_en_i && (wr_addr_i == AW'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  valid_o[i] <= 1'b0;
      else if (sel) valid_o[i] <= wr_valid_i;
    end

    always_ff @(posedge clk_i) begin
      if (sel) words_o[i] <= wr_data_i;
    end
  end

  assert_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (valid_o[$past(wr_addr_i)] == $past(wr_valid_i)) &&
                (words_o[$past(wr_addr_i)] == $past(wr_data_i)));
endmodule

// File: rtl/mcam_compare.sv
module mcam_compare #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned WIDTH   = 16
) (
  input  logic [ENTRIES-1:0][WIDTH-1:0] words_i,
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [WIDTH-1:0]              arg_i,
  input  logic [WIDTH-1:0]              key_i,
  output logic [ENTRIES-1:0]            hit_o
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    // a differing bit only counts where the key enables it
    assign hit_o[i] = valid_i[i] && ~|((words_i[i] ^ arg_i) & key_i);
  end
endmodule

// File: rtl/mcam_prio.sv
module mcam_prio #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned AW     = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] req_i,
  output logic               any_o,
  output logic [AW-1:0]      idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = AW'(i);
      end
    end
  end
endmodule

// File: rtl/mcam_top.sv
module mcam_top import mcam_pkg::*; #(
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  parameter int unsigned WIDTH   = DEF_WIDTH,
  localparam int unsigned AW     = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [WIDTH-1:0]   wr_data_i,
  input  logic               wr_valid_i,
  input  logic               srch_en_i,
  input  logic [WIDTH-1:0]   arg_i,
  input  logic [WIDTH-1:0]   key_i,
  output logic [ENTRIES-1:0] match_o,
  output logic               hit_o,
  output logic [AW-1:0]      hit_idx_o,
  output logic [WIDTH-1:0]   rd_data_o
);
  logic [ENTRIES-1:0][WIDTH-1:0] words;
  logic [ENTRIES-1:0]            valid;
  logic [ENTRIES-1:0]            cmp_hit;
  logic [ENTRIES-1:0]            match_q;

  mcam_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .wr_valid_i,
    .words_o(words), .valid_o(valid)
  );

  mcam_compare #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_cmp (
    .words_i(words), .valid_i(valid), .arg_i, .key_i, .hit_o(cmp_hit)
  );

  // compare sees pre-edge contents, so a same-cycle write waits for the next search
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        match_q <= '0;
    else if (srch_en_i) match_q <= cmp_hit;
  end

  mcam_prio #(.ENTRIES(ENTRIES)) u_prio (
    .req_i(match_q), .any_o(hit_o), .idx_o(hit_idx_o)
  );

  assign match_o   = match_q;
  assign rd_data_o = words[hit_idx_o];

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srch_en_i |=> $stable(match_q));
  assert_invalid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srch_en_i |=> ((match_q & ~$past(valid)) == '0));
  assert_zero_key_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srch_en_i && key_i == '0) |=> (match_q == $past(valid)));
  assert_any_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o == (match_q != '0));
  assert_lowest_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (match_q[hit_idx_o] &&
               ((match_q & ((ENTRIES'(1) << hit_idx_o) - 1'b1)) == '0)));
endmodule

// File: tb/mcam_top_test.sv
`timescale 1ns/1ps
module mcam_top_test;
  localparam int unsigned N  = 8;
  localparam int unsigned W  = 16;
  localparam int unsigned AW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_valid = 1'b0, srch_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0]  wr_data = '0, arg = '0, key = '0;
  logic [N-1:0]  match;
  logic          hit;
  logic [AW-1:0] hit_idx;
  logic [W-1:0]  rd_data;

  int total = 0, bad = 0;
  logic [W-1:0] mem_m [N];
  logic         val_m [N];

  always #2.5 clk = ~clk;

  mcam_top #(.ENTRIES(N), .WIDTH(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wr_valid_i(wr_valid), .srch_en_i(srch_en),
    .arg_i(arg), .key_i(key), .match_o(match), .hit_o(hit),
    .hit_idx_o(hit_idx), .rd_data_o(rd_data)
  );

  // each row: argument, key
  localparam logic [31:0] VEC [7] = '{
    {16'h12A4, 16'hFFFF},   // exact, two entries
    {16'h00A4, 16'h00FF},   // low byte only
    {16'h0000, 16'h0000},   // zero key
    {16'h0000, 16'hFFFF},   // matches only an invalid word
    {16'hFFFF, 16'hFF00},   // high byte FF
    {16'h5A00, 16'hFF00},   // single entry
    {16'hBEEF, 16'hFFFF}    // no match
  };

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(int a, logic [W-1:0] d, logic v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; wr_valid = v;
    @(negedge clk);
    wr_en = 1'b0;
    mem_m[a] = d; val_m[a] = v;
  endtask

  function automatic logic [N-1:0] model(logic [W-1:0] a, logic [W-1:0] k);
    logic [N-1:0] m = '0;
    for (int i = 0; i < N; i++)
      m[i] = val_m[i] && ((mem_m[i] & k) == (a & k));
    return m;
  endfunction

  task automatic search_check(string req, logic [W-1:0] a, logic [W-1:0] k);
    logic [N-1:0] e;
    e = model(a, k);
    @(negedge clk);
    srch_en = 1'b1; arg = a; key = k;
    @(negedge clk);
    srch_en = 1'b0;
    check({req, " match"}, 32'(match), 32'(e));
    check("R7 hit", 32'(hit), 32'(e != '0));
    for (int i = 0; i < N; i++) begin
      if (e[i]) begin
        check("R6 idx", 32'(hit_idx), 32'(i));
        check("R6 data", 32'(rd_data), 32'(mem_m[i]));
        break;
      end
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [N-1:0] held;
    for (int i = 0; i < N; i++) begin mem_m[i] = '0; val_m[i] = 1'b0; end
    repeat (3) @(negedge clk);
    check("R1 match reset", 32'(match), 0);
    check("R1 hit reset", 32'(hit), 0);
    rst_n = 1'b1;
    search_check("R1 empty", 16'h0000, 16'h0000);

    wr(0, 16'h12A4, 1'b1);
    wr(1, 16'h34A4, 1'b1);
    wr(2, 16'h12FF, 1'b1);
    wr(4, 16'h5A5A, 1'b1);
    wr(5, 16'h12A4, 1'b1);
    wr(6, 16'hFFFF, 1'b1);
    wr(7, 16'h0000, 1'b0);     // R5: stored but invalid

    for (int v = 0; v < 7; v++)
      search_check("R3 R4 R5 R9 vec", VEC[v][31:16], VEC[v][15:0]);

    // R10: idle cycles with changing inputs keep the register
    search_check("R10 setup", 16'h00A4, 16'h00FF);
    held = match;
    @(negedge clk); arg = 16'hFFFF; key = 16'h0000;
    repeat (3) @(negedge clk);
    check("R10 hold", 32'(match), 32'(held));

    // R8: write during search is invisible to that search
    @(negedge clk);
    srch_en = 1'b1; arg = 16'hABCD; key = 16'hFFFF;
    wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'hABCD; wr_valid = 1'b1;
    @(negedge clk);
    srch_en = 1'b0; wr_en = 1'b0;
    mem_m[3] = 16'hABCD; val_m[3] = 1'b1;
    check("R8 same cycle", 32'(match), 0);
    search_check("R8 next", 16'hABCD, 16'hFFFF);

    // R2: invalidate and overwrite
    wr(0, 16'h0000, 1'b0);
    search_check("R2 invalidate", 16'h12A4, 16'hFFFF);
    check("R2 idx moves", 32'(hit_idx), 5);
    wr(5, 16'h7777, 1'b1);
    search_check("R2 overwrite", 16'h7777, 16'hFFFF);
    search_check("R9 zero key", 16'h1234, 16'h0000);
    finish_run();
  end
endmodule